// File: doc/BRIEF.md
# Time-shared symmetric FIR filter

This block is a single-channel FIR filter whose coefficients are mirror-symmetric. Each pair of mirrored taps is folded by a pre-adder, so one multiplication serves both taps. The folded products are then spread over several clock cycles of each sample period. The number of cycles per sample is the time-sharing factor, which is the ratio of the clock frequency to the sample rate. The block therefore needs only ceil(ceil(NTAPS/2) / TDM) physical multipliers. With 49 taps this gives 25 multipliers at factor 1, 13 at factor 2 and 7 at factor 4.

A serializer holds the delay line and a phase counter. In each phase it chooses which folded pairs and coefficients feed the shared multiplier lanes. A multiply-accumulate stage sums the lane products of every phase into one accumulator, and that accumulator restarts on the first phase of each period. A deserializer captures the finished sum and presents it with a one-cycle valid strobe.

The coefficients are not loaded at run time. They are computed from the seed parameter. The output carries the full-precision sum, with no rounding and no saturation.

Top module: `tsf_fir`

## Requirements
- R1: Each result equals the sum over j = 0..NTAPS-1 of h[j]·x[n-j], where h[j] = c(min(j, NTAPS-1-j)) and c(k) = ((37·k + 11·COEF_SEED) mod 201) - 100. x[n] is the newest accepted sample. For an odd tap count the centre tap is counted once.
- R2: A sample is accepted when in_valid is high and either no sample period is running or the running period is in its last cycle. Accepted samples are therefore at least TDM cycles apart. An in_valid that arrives sooner is ignored: it changes neither the delay line nor any later result.
- R3: The result for a sample is presented with out_valid high in the cycle that follows the (TDM+2)-th rising edge after the edge that accepted the sample.
- R4: There is exactly one out_valid cycle per accepted sample. When TDM > 1, out_valid never stays high for two consecutive cycles.
- R5: With an even tap count, every folded pair adds two distinct delay-line entries, and there is no centre term.
- R6: While rst_n is low, out_valid is 0 and out_data is 0. After reset the delay line holds zeros, so the first NTAPS-1 results see zero history.
- R7: Full-scale inputs (+32767 and -32768 for 16-bit data) give exact results. The pre-adder is DATA_W+1 bits wide and the accumulator is PRE_W+COEF_W+clog2(ceil(NTAPS/2))+1 bits wide, so nothing wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a finished result |
| out_data | output | ACC_W | Signed full-precision filter result |

## Verification
The bench builds two instances. The first has 49 taps and factor 4, which gives seven lanes over 28 slots, so three slots are empty and the lone centre tap sits in the last phase. The second has 10 taps and factor 3, which gives an even length with two lanes and one unused slot. Between them they cover the odd and even folding paths and the partly filled final phase. The stimulus mixes an impulse, which exposes every coefficient directly, with valid held high every cycle, which exercises the ignore path. It also includes alternating full-scale blocks and random data. Together these reach the ignore rule, the latency at the largest period and the widest sums.

// File: rtl/tsf_pkg.sv
`timescale 1ns/1ps
package tsf_pkg;

  // Folded coefficient k of the symmetric response for a given seed.
  function automatic int coef_at(input int k, input int seed);
    return ((37 * k + 11 * seed) % 201) - 100;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/tsf_serializer.sv
`timescale 1ns/1ps
module tsf_serializer #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 12,
  parameter int NTAPS     = 49,
  parameter int TDM       = 4,
  parameter int COEF_SEED = 3,
  localparam int HALF  = (NTAPS + 1) / 2,
  localparam int MULTS = tsf_pkg::ceil_div(HALF, TDM),
  localparam int PRE_W = DATA_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic signed [DATA_W-1:0]       in_data,
  output logic [MULTS-1:0][PRE_W-1:0]    pre_q,
  output logic [MULTS-1:0][COEF_W-1:0]   coef_q,
  output logic                           s_valid,
  output logic                           s_first,
  output logic                           s_last
);

  localparam int CNT_W = (TDM > 1) ? $clog2(TDM) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TDM - 1);

  // Sign-extend both operands, then add. The centre tap of an odd-length filter is not doubled.
  function automatic logic signed [PRE_W-1:0] fold_pair(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b,
    input logic                     solo
  );
    logic signed [PRE_W-1:0] ea, eb;
    ea = $signed({a[DATA_W-1], a});
    eb = solo ? '0 : $signed({b[DATA_W-1], b});
    return ea + eb;
  endfunction

  logic signed [DATA_W-1:0] line [NTAPS];
  logic                     active;
  logic [CNT_W-1:0]         cnt;
  logic                     can_take;
  logic                     accept;

  assign can_take = !active || (cnt == LAST_CNT);
  assign accept   = in_valid && can_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST_CNT) active <= 1'b0;
      else                  cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) line[i] <= '0;
    end else if (accept) begin
      line[0] <= in_data;
      for (int i = 1; i < NTAPS; i++) line[i] <= line[i-1];
    end
  end

  logic signed [PRE_W-1:0]  fold_w [HALF];
  logic signed [COEF_W-1:0] coef_w [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_fold
    localparam bit SOLO = (k == NTAPS - 1 - k);
    localparam logic signed [COEF_W-1:0] CK = COEF_W'(tsf_pkg::coef_at(k, COEF_SEED));
    assign fold_w[k] = fold_pair(line[k], line[NTAPS-1-k], SOLO);
    assign coef_w[k] = CK;
  end

  // Lane l in phase p takes folded index p*MULTS + l; indices beyond the last pair give zero.
  logic [MULTS-1:0][PRE_W-1:0]  pre_c;
  logic [MULTS-1:0][COEF_W-1:0] coef_c;

  always_comb begin
    for (int l = 0; l < MULTS; l++) begin
      pre_c[l]  = '0;
      coef_c[l] = '0;
      for (int k = 0; k < HALF; k++) begin
        if (k == int'(cnt) * MULTS + l) begin
          pre_c[l]  = fold_w[k];
          coef_c[l] = coef_w[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_first <= 1'b0;
      s_last  <= 1'b0;
      pre_q   <= '0;
      coef_q  <= '0;
    end else begin
      s_valid <= active;
      s_first <= (cnt == '0);
      s_last  <= (cnt == LAST_CNT);
      pre_q   <= pre_c;
      coef_q  <= coef_c;
    end
  end

  if (TDM > 1) begin : g_gap_chk
    assert_accept_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept);
  end

  assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(line[0]));

endmodule

// File: rtl/tsf_mac.sv
`timescale 1ns/1ps
module tsf_mac #(
  parameter int PRE_W  = 17,
  parameter int COEF_W = 12,
  parameter int MULTS  = 7,
  parameter int ACC_W  = 35,
  localparam int PROD_W = PRE_W + COEF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [MULTS-1:0][PRE_W-1:0]  pre_in,
  input  logic [MULTS-1:0][COEF_W-1:0] coef_in,
  input  logic                         in_valid,
  input  logic                         in_first,
  input  logic                         in_last,
  output logic                         done,
  output logic signed [ACC_W-1:0]      total
);

  // Full-width signed product of a folded pair and its coefficient.
  function automatic logic signed [PROD_W-1:0] scale(
    input logic signed [PRE_W-1:0]  p,
    input logic signed [COEF_W-1:0] c
  );
    logic signed [PROD_W-1:0] r;
    r = $signed({{COEF_W{p[PRE_W-1]}}, p}) * $signed({{PRE_W{c[COEF_W-1]}}, c});
    return r;
  endfunction

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PROD_W-1:0] v);
    return $signed({{(ACC_W-PROD_W){v[PROD_W-1]}}, v});
  endfunction

  logic signed [PROD_W-1:0] prod_q [MULTS];
  logic p_valid, p_first, p_last;

  for (genvar l = 0; l < MULTS; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q[l] <= '0;
      else        prod_q[l] <= scale($signed(pre_in[l]), $signed(coef_in[l]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_first <= 1'b0;
      p_last  <= 1'b0;
    end else begin
      p_valid <= in_valid;
      p_first <= in_first;
      p_last  <= in_last;
    end
  end

  logic signed [ACC_W-1:0] lane_sum;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_next;

  always_comb begin
    lane_sum = '0;
    for (int l = 0; l < MULTS; l++) lane_sum = lane_sum + widen(prod_q[l]);
  end

  assign acc_next = p_first ? lane_sum : acc_q + lane_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (p_valid) acc_q <= acc_next;
  end

  assign total = acc_next;
  assign done  = p_valid && p_last;

  // A period's phases arrive back to back, so the accumulation covers exactly one sample.
  assert_phase_contiguous_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !p_first) |-> $past(p_valid));

endmodule

// File: rtl/tsf_deser.sv
`timescale 1ns/1ps
module tsf_deser #(
  parameter int ACC_W = 35
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    done,
  input  logic signed [ACC_W-1:0] total,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= done;
      if (done) out_data <= total;
    end
  end

endmodule

// File: rtl/tsf_fir.sv
`timescale 1ns/1ps
module tsf_fir #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 12,
  parameter int NTAPS     = 49,
  parameter int TDM       = 4,
  parameter int COEF_SEED = 3,
  localparam int HALF  = (NTAPS + 1) / 2,
  localparam int MULTS = tsf_pkg::ceil_div(HALF, TDM),
  localparam int PRE_W = DATA_W + 1,
  localparam int ACC_W = PRE_W + COEF_W + $clog2(HALF) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);

  logic [MULTS-1:0][PRE_W-1:0]  pre_q;
  logic [MULTS-1:0][COEF_W-1:0] coef_q;
  logic                         s_valid, s_first, s_last;
  logic                         mac_done;
  logic signed [ACC_W-1:0]      mac_total;

  tsf_serializer #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .TDM(TDM), .COEF_SEED(COEF_SEED)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .pre_q(pre_q), .coef_q(coef_q),
    .s_valid(s_valid), .s_first(s_first), .s_last(s_last)
  );

  tsf_mac #(
    .PRE_W(PRE_W), .COEF_W(COEF_W), .MULTS(MULTS), .ACC_W(ACC_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .pre_in(pre_q), .coef_in(coef_q),
    .in_valid(s_valid), .in_first(s_first), .in_last(s_last),
    .done(mac_done), .total(mac_total)
  );

  tsf_deser #(.ACC_W(ACC_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .done(mac_done), .total(mac_total),
    .out_valid(out_valid), .out_data(out_data)
  );

  // The result leaves exactly two registers after the serializer flags the last phase.
  assert_out_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s_valid && s_last, 2));

  if (TDM > 1) begin : g_pulse_chk
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
  end

endmodule

// File: tb/tsf_fir_test.sv
`timescale 1ns/1ps
module tsf_scoreboard #(
  parameter int NTAPS = 49,
  parameter int TDM   = 4,
  parameter int SEED  = 3,
  parameter int OUT_W = 35
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  int                      cyc,
  input  logic                    in_valid,
  input  logic signed [15:0]      in_data,
  input  logic                    out_valid,
  input  logic signed [OUT_W-1:0] out_data,
  output int                      n_chk,
  output int                      n_bad,
  output int                      pending
);
  longint hist [64];
  longint exp_q [$];
  int     due_q [$];
  string  tag_q [$];
  bit     seen = 0;
  bit     ign  = 0;
  int     last_acc = 0;
  int     n_acc = 0;

  // Folded coefficient per the R1 formula, mirrored about the centre.
  function automatic longint tap(input int j);
    int k;
    k = (j < NTAPS - 1 - j) ? j : NTAPS - 1 - j;
    return longint'((37 * k + 11 * SEED) % 201) - 100;
  endfunction

  initial begin
    n_chk = 0; n_bad = 0; pending = 0;
    for (int i = 0; i < 64; i++) hist[i] = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        n_chk++;
        if (due_q.size() == 0) begin
          n_bad++;
          $display("FAIL R4: unexpected out_valid at cycle %0d, got %0d expected none", cyc, out_data);
        end else begin
          if (due_q[0] != cyc) begin
            n_bad++;
            $display("FAIL R3: result at cycle %0d expected cycle %0d", cyc, due_q[0]);
          end else if (longint'(out_data) != exp_q[0]) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag_q[0], out_data, exp_q[0]);
          end
          void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        n_chk++; n_bad++;
        $display("FAIL R3: no out_valid at cycle %0d, got 0 expected 1", cyc);
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
      end
      if (in_valid) begin
        if (!seen || cyc - last_acc >= TDM) begin
          longint acc;
          int     ext;
          seen = 1; last_acc = cyc; n_acc++;
          for (int j = NTAPS - 1; j > 0; j--) hist[j] = hist[j-1];
          hist[0] = longint'(in_data);
          acc = 0; ext = 0;
          for (int j = 0; j < NTAPS; j++) begin
            acc += tap(j) * hist[j];
            if (hist[j] == 32767 || hist[j] == -32768) ext++;
          end
          exp_q.push_back(acc);
          due_q.push_back(cyc + TDM + 3);
          if (ign)                 tag_q.push_back("R2");
          else if (ext > 0)        tag_q.push_back("R7");
          else if (n_acc < NTAPS)  tag_q.push_back("R6");
          else if (NTAPS % 2 == 0) tag_q.push_back("R5");
          else                     tag_q.push_back("R1");
          ign = 0;
        end else begin
          ign = 1;
        end
      end
      pending = due_q.size();
    end
  end
endmodule

module tsf_fir_test;
  localparam int NT_A = 49, TD_A = 4, SD_A = 3;
  localparam int NT_B = 10, TD_B = 3, SD_B = 5;
  localparam int OW_A = 17 + 12 + $clog2((NT_A + 1) / 2) + 1;
  localparam int OW_B = 17 + 12 + $clog2((NT_B + 1) / 2) + 1;
  localparam int STEPS = 6000;

  logic clk = 0;
  logic rst_n = 0;
  int   cyc = 0;
  int   chk = 0, bad = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic                   va = 0, vb = 0;
  logic signed [15:0]     da = 0, db = 0;
  logic                   ova, ovb;
  logic signed [OW_A-1:0] oda;
  logic signed [OW_B-1:0] odb;
  int ca, ba, pa, cb, bb, pb;

  tsf_fir #(.DATA_W(16), .COEF_W(12), .NTAPS(NT_A), .TDM(TD_A), .COEF_SEED(SD_A)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(va), .in_data(da), .out_valid(ova), .out_data(oda));

  tsf_fir #(.DATA_W(16), .COEF_W(12), .NTAPS(NT_B), .TDM(TD_B), .COEF_SEED(SD_B)) uut_even (
    .clk(clk), .rst_n(rst_n), .in_valid(vb), .in_data(db), .out_valid(ovb), .out_data(odb));

  tsf_scoreboard #(.NTAPS(NT_A), .TDM(TD_A), .SEED(SD_A), .OUT_W(OW_A)) sb_a (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .in_valid(va), .in_data(da),
    .out_valid(ova), .out_data(oda), .n_chk(ca), .n_bad(ba), .pending(pa));

  tsf_scoreboard #(.NTAPS(NT_B), .TDM(TD_B), .SEED(SD_B), .OUT_W(OW_B)) sb_b (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .in_valid(vb), .in_data(db),
    .out_valid(ovb), .out_data(odb), .n_chk(cb), .n_bad(bb), .pending(pb));

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    chk++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic set_in(input int which, input logic v, input logic signed [15:0] d);
    if (which == 0) begin va = v; da = d; end
    else            begin vb = v; db = d; end
  endtask

  // Impulse, then valid every cycle with full scale, then random traffic.
  task automatic run_stim(input int which, input int tdm);
    for (int i = 0; i < STEPS; i++) begin
      logic v;
      logic signed [15:0] d;
      @(posedge clk); #1;
      if (i < 240) begin
        v = (i % tdm == 0);
        d = (i == 0) ? 16'sd1000 : 16'sd0;
      end else if (i < 480) begin
        v = 1'b1;
        d = (i < 360) ? 16'sh7fff : 16'sh8000;
      end else if (i < 560) begin
        v = 1'b1;
        d = ((i / tdm) % 2 != 0) ? 16'sh7fff : 16'sh8000;
      end else begin
        int r;
        v = ($urandom % 3) != 0;
        r = $urandom % 8;
        d = (r == 0) ? 16'sh7fff : (r == 1) ? 16'sh8000 : 16'($urandom);
      end
      set_in(which, v, d);
    end
    @(posedge clk); #1;
    set_in(which, 1'b0, 16'sd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ova == 1'b0, "R6", longint'(ova), 0);
    check(oda == '0,   "R6", longint'(oda), 0);
    check(ovb == 1'b0, "R6", longint'(ovb), 0);
    check(odb == '0,   "R6", longint'(odb), 0);
    @(negedge clk);
    rst_n = 1;
    fork
      run_stim(0, TD_A);
      run_stim(1, TD_B);
    join
    repeat (30) @(negedge clk);
    check(pa == 0, "R4", longint'(pa), 0);
    check(pb == 0, "R4", longint'(pb), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", chk + ca + cb, bad + ba + bb);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", chk + ca + cb + 1, bad + ba + bb + 1);
      $finish;
    end
  end
endmodule